// File: doc/BRIEF.md
# Fair Round-Robin Stream Issue Scheduler

This block chooses, on each clock, one hardware thread context (a "stream") from a large pool to feed a single shared instruction pipeline. A stream is a candidate when its ready input is high, its blocked input is low, and it has fewer memory requests in flight than a fixed per-stream cap. The blocked input is held high by the surrounding logic while a stream waits on a synchronizing load or store. When it is high, the scheduler skips that stream and keeps issuing from the others.

Fairness comes from a rotating priority pointer. The grant goes to the first candidate found scanning upward from the pointer, wrapping at the top of the pool. After each grant the pointer moves to the position just past the granted stream. The block also keeps one in-flight counter per stream. Memory-issue events raise the counter, completion events lower it, and each event carries a stream number. The grant leaves on a valid strobe with no back-pressure: the pipeline takes every grant in the cycle it is offered, and the grant is a combinational function of the current inputs and the held state. No grant is offered in a cycle with no candidate.

Top module: `stream_issue_sched`

## Requirements
- R1: `grant_vld` is high in a cycle exactly when at least one stream is a candidate. A candidate has ready high, blocked low and an in-flight count below `MAX_OUTST`.
- R2: Whenever `grant_vld` is high, `grant_id` names a candidate stream.
- R3: The granted stream is the first candidate met when scanning indices upward from the rotation pointer, with the scan wrapping from `NUM_STREAMS-1` to 0. After a grant, the pointer becomes `grant_id+1`, or 0 when `grant_id` is `NUM_STREAMS-1`.
- R4: In a cycle with no candidate, `grant_vld` is 0, `grant_id` is 0 and the pointer does not move.
- R5: A memory-issue event raises the named stream's in-flight count by one. A completion event lowers it by one.
- R6: A stream whose count has reached `MAX_OUTST` (default 8) is never granted until a completion for that stream arrives.
- R7: An issue and a completion naming the same stream in the same cycle leave that stream's count unchanged.
- R8: An issue to a stream already at `MAX_OUTST` is dropped. A completion to a stream with a count of zero is dropped.
- R9: After reset, the pointer is 0 and every count is 0. With all streams ready and unblocked, the first grant is stream 0 and the following grants go 1, 2, 3 and so on.
- R10: A stream with blocked high is never granted even while ready, and the other candidates keep being granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strm_ready | input | NUM_STREAMS | Per-stream ready flag, bit i for stream i |
| strm_blocked | input | NUM_STREAMS | Per-stream blocked flag (synchronizing access pending) |
| mem_issue_vld | input | 1 | A memory request was sent for stream `mem_issue_id` |
| mem_issue_id | input | $clog2(NUM_STREAMS) | Stream number of the memory request |
| mem_done_vld | input | 1 | A memory request completed for stream `mem_done_id` |
| mem_done_id | input | $clog2(NUM_STREAMS) | Stream number of the completion |
| grant_vld | output | 1 | A stream is issued this cycle |
| grant_id | output | $clog2(NUM_STREAMS) | Issued stream number, 0 when `grant_vld` is low |

## Verification
The scheduler is driven through several ready patterns. With every stream ready, the rotation must produce an exact increasing sequence. With dense random ready masks, the check is that the pointer skips only non-candidates. With sparse masks of a few bits, the scan must wrap around the top of the pool. Random blocked masks separate the blocked input from the ready input.

Memory traffic is focused on a handful of streams so that counters repeatedly reach the cap. This exercises dropped issues at the cap, dropped completions at zero, and same-cycle issue and completion pairs. A behavioural model predicts the grant in every cycle, so an error in the counters shows up as a wrong grant decision at the ports.

// File: rtl/sis_pkg.sv
package sis_pkg;
  // Next position in a ring of n slots.
  function automatic int ring_next(input int v, input int n);
    return (v >= n - 1) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/sis_outst_counter.sv
// Per-stream in-flight memory request counter, saturating at MAXC.
module sis_outst_counter #(
  parameter int MAXC = 8,
  parameter int CW   = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic          at_cap,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CAP = CW'(MAXC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (inc && dec) begin
      cnt <= cnt;                          // R7: simultaneous pair cancels
    end else if (inc && cnt != CAP) begin
      cnt <= cnt + 1'b1;                   // R5, R8: issue dropped at cap
    end else if (dec && cnt != '0) begin
      cnt <= cnt - 1'b1;                   // R5, R8: completion dropped at zero
    end
  end

  assign at_cap = (cnt == CAP);            // R6
endmodule

// File: rtl/sis_rr_pick.sv
// Rotating-priority picker: lowest candidate at or above ptr, else lowest overall.
module sis_rr_pick #(
  parameter int N   = 128,
  parameter int IDW = $clog2(N)
) (
  input  logic [N-1:0]   cand,
  input  logic [IDW-1:0] ptr,
  output logic           any,
  output logic [IDW-1:0] sel
);
  logic [N-1:0]   upper;
  logic [IDW-1:0] sel_up;
  logic [IDW-1:0] sel_all;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      upper[i] = cand[i] && (IDW'(i) >= ptr);
    end
  end

  always_comb begin
    sel_up  = '0;
    sel_all = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (upper[i]) sel_up  = IDW'(i);
      if (cand[i])  sel_all = IDW'(i);
    end
  end

  assign any = |cand;
  // R3: wrap to the bottom only when nothing sits at or above the pointer
  assign sel = !any ? '0 : ((|upper) ? sel_up : sel_all);
endmodule

// File: rtl/stream_issue_sched.sv
module stream_issue_sched #(
  parameter int NUM_STREAMS = 128,
  parameter int MAX_OUTST   = 8,
  localparam int IDW        = $clog2(NUM_STREAMS),
  localparam int CW         = $clog2(MAX_OUTST + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_STREAMS-1:0] strm_ready,
  input  logic [NUM_STREAMS-1:0] strm_blocked,
  input  logic                   mem_issue_vld,
  input  logic [IDW-1:0]         mem_issue_id,
  input  logic                   mem_done_vld,
  input  logic [IDW-1:0]         mem_done_id,
  output logic                   grant_vld,
  output logic [IDW-1:0]         grant_id
);
  logic [NUM_STREAMS-1:0]    at_cap;
  logic [NUM_STREAMS-1:0]    cand;
  logic [NUM_STREAMS*CW-1:0] outst_flat;
  logic [IDW-1:0]            rr_ptr;
  logic                      pick_any;
  logic [IDW-1:0]            pick_sel;

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_cnt
    logic inc_g;
    logic dec_g;
    assign inc_g = mem_issue_vld && (mem_issue_id == IDW'(g));
    assign dec_g = mem_done_vld  && (mem_done_id  == IDW'(g));
    sis_outst_counter #(.MAXC(MAX_OUTST), .CW(CW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (inc_g),
      .dec    (dec_g),
      .at_cap (at_cap[g]),
      .cnt    (outst_flat[g*CW +: CW])
    );
  end

  // R1, R6, R10: candidacy
  assign cand = strm_ready & ~strm_blocked & ~at_cap;

  sis_rr_pick #(.N(NUM_STREAMS), .IDW(IDW)) u_pick (
    .cand (cand),
    .ptr  (rr_ptr),
    .any  (pick_any),
    .sel  (pick_sel)
  );

  assign grant_vld = pick_any;
  assign grant_id  = pick_sel;

  // R3, R4, R9: pointer moves past the winner, holds when idle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (pick_any) begin
      rr_ptr <= IDW'(sis_pkg::ring_next(int'(pick_sel), NUM_STREAMS));
    end
  end
endmodule

// File: rtl/sis_chk.sv
module sis_chk #(
  parameter int N    = 128,
  parameter int MAXC = 8,
  parameter int IDW  = $clog2(N),
  parameter int CW   = $clog2(MAXC + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   strm_ready,
  input logic [N-1:0]   strm_blocked,
  input logic           mem_issue_vld,
  input logic [IDW-1:0] mem_issue_id,
  input logic           mem_done_vld,
  input logic [IDW-1:0] mem_done_id,
  input logic           grant_vld,
  input logic [IDW-1:0] grant_id,
  input logic [IDW-1:0] rr_ptr,
  input logic [N*CW-1:0] outst_flat
);
  logic [IDW-1:0] after_grant;
  logic [CW-1:0]  issue_cnt;
  logic [CW-1:0]  grant_cnt;

  assign after_grant = (grant_id == IDW'(N - 1)) ? '0 : grant_id + 1'b1;
  assign issue_cnt   = outst_flat[int'(mem_issue_id)*CW +: CW];
  assign grant_cnt   = outst_flat[int'(grant_id)*CW +: CW];

  // R2
  grant_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> (strm_ready[grant_id] && !strm_blocked[grant_id] && grant_cnt != CW'(MAXC)));

  // R1
  no_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(strm_ready & ~strm_blocked)) |-> !grant_vld);

  // R3
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |=> rr_ptr == $past(after_grant));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_vld |=> $stable(rr_ptr));

  // R7
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_issue_vld && mem_done_vld && mem_issue_id == mem_done_id)
      |=> outst_flat[int'($past(mem_issue_id))*CW +: CW] == $past(issue_cnt));

  for (genvar g = 0; g < N; g++) begin : g_cap
    // R6
    cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      outst_flat[g*CW +: CW] <= CW'(MAXC));
  end
endmodule

bind stream_issue_sched sis_chk #(
  .N(NUM_STREAMS), .MAXC(MAX_OUTST), .IDW(IDW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .strm_ready(strm_ready), .strm_blocked(strm_blocked),
  .mem_issue_vld(mem_issue_vld), .mem_issue_id(mem_issue_id),
  .mem_done_vld(mem_done_vld), .mem_done_id(mem_done_id),
  .grant_vld(grant_vld), .grant_id(grant_id), .rr_ptr(rr_ptr), .outst_flat(outst_flat)
);

// File: tb/tb_stream_issue_sched.sv
`timescale 1ns/1ps
module tb_stream_issue_sched;
  localparam int N   = 128;
  localparam int MX  = 8;
  localparam int IDW = $clog2(N);

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   ready;
  logic [N-1:0]   blocked;
  logic           iss_v;
  logic [IDW-1:0] iss_id;
  logic           dn_v;
  logic [IDW-1:0] dn_id;
  logic           gv;
  logic [IDW-1:0] gid;

  int  n_cmp  = 0;
  int  n_bad  = 0;
  bit  ended  = 0;
  int  mcnt[N];
  int  mptr;

  always #10 clk = ~clk;

  stream_issue_sched #(.NUM_STREAMS(N), .MAX_OUTST(MX)) dut (
    .clk(clk), .rst_n(rst_n), .strm_ready(ready), .strm_blocked(blocked),
    .mem_issue_vld(iss_v), .mem_issue_id(iss_id),
    .mem_done_vld(dn_v), .mem_done_id(dn_id),
    .grant_vld(gv), .grant_id(gid)
  );

  function automatic bit is_cand(input int s);
    return ready[s] && !blocked[s] && (mcnt[s] < MX);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One cycle: compare against the model mid-cycle, then advance the model at the edge.
  task automatic tick(input string tag);
    int ev;
    int eid;
    #2;
    ev  = 0;
    eid = 0;
    for (int k = 0; k < N; k++) begin
      int s;
      s = (mptr + k) % N;
      if (ev == 0 && is_cand(s)) begin
        ev  = 1;
        eid = s;
      end
    end
    n_cmp++;
    if (int'(gv) != ev || int'(gid) != eid) begin
      n_bad++;
      $display("FAIL %s: actual vld=%0d id=%0d expected vld=%0d id=%0d",
               tag, gv, gid, ev, eid);
    end
    @(posedge clk);
    if (ev == 1) mptr = (eid + 1) % N;
    if (iss_v && dn_v && iss_id == dn_id) begin
      // R7: pair leaves count unchanged
    end else begin
      if (iss_v && mcnt[iss_id] < MX) mcnt[iss_id]++;
      if (dn_v && mcnt[dn_id] > 0) mcnt[dn_id]--;
    end
    @(negedge clk);
  endtask

  task automatic idle_ev();
    iss_v = 0; dn_v = 0; iss_id = '0; dn_id = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ready = '0; blocked = '0; idle_ev();
    for (int s = 0; s < N; s++) mcnt[s] = 0;
    mptr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R9 / R4: reset state, nothing ready -> no grant
    #2;
    check("R4 idle after reset vld", int'(gv), 0);
    check("R4 idle after reset id", int'(gid), 0);
    tick("R4 idle");

    // R9 / R3: all ready -> 0,1,2,... rotation
    ready = '1;
    #2;
    check("R9 first grant", int'(gid), 0);
    for (int c = 0; c < N + 10; c++) tick("R9 R3 full rotation");

    // R1 R3: dense random ready masks
    for (int c = 0; c < 400; c++) begin
      for (int b = 0; b < N; b++) ready[b] = ($urandom % 10) != 0;
      tick("R1 R3 dense");
    end

    // R3 R4: sparse masks force wrap-around and idle cycles
    for (int c = 0; c < 400; c++) begin
      ready = '0;
      for (int k = 0; k < 3; k++) if ($urandom % 2) ready[$urandom % N] = 1'b1;
      tick("R3 R4 sparse");
    end

    // R10: blocked streams skipped, others continue
    for (int c = 0; c < 400; c++) begin
      ready = '1;
      for (int b = 0; b < N; b++) blocked[b] = $urandom % 2;
      tick("R10 blocked");
    end
    blocked = '0;

    // R6 R5: only stream 5 ready, fill to cap
    ready = '0; ready[5] = 1'b1;
    iss_v = 1; iss_id = IDW'(5);
    for (int c = 0; c < MX; c++) tick("R5 fill");
    idle_ev();
    #2;
    check("R6 at cap no grant", int'(gv), 0);
    tick("R6 at cap");
    // R8: extra issue at cap dropped
    iss_v = 1; iss_id = IDW'(5);
    tick("R8 issue at cap");
    // R7: pair at cap keeps it ineligible
    iss_v = 1; iss_id = IDW'(5); dn_v = 1; dn_id = IDW'(5);
    tick("R7 pair at cap");
    idle_ev();
    #2;
    check("R7 still capped", int'(gv), 0);
    dn_v = 1; dn_id = IDW'(5);
    tick("R6 completion");
    idle_ev();
    #2;
    check("R8 one completion frees slot", int'(gv), 1);
    check("R6 freed stream id", int'(gid), 5);
    // drain stream 5, then extra completions at zero dropped
    dn_v = 1; dn_id = IDW'(5);
    for (int c = 0; c < MX + 3; c++) tick("R8 drain past zero");
    dn_v = 0; iss_v = 1; iss_id = IDW'(5);
    for (int c = 0; c < MX - 1; c++) tick("R8 refill");
    idle_ev();
    #2;
    check("R8 seven issued still eligible", int'(gv), 1);
    tick("R8 seven");
    iss_v = 1; iss_id = IDW'(5);
    tick("R8 eighth");
    idle_ev();
    #2;
    check("R8 eight issued capped", int'(gv), 0);

    // R5 R6 R7 R8: heavy traffic on streams 0..7
    for (int c = 0; c < 1500; c++) begin
      for (int b = 0; b < N; b++) ready[b] = (b < 12) ? 1'b1 : (($urandom % 8) == 0);
      iss_v = ($urandom % 4) != 0; iss_id = IDW'($urandom % 8);
      dn_v  = ($urandom % 3) == 0; dn_id  = ($urandom % 4 == 0) ? iss_id : IDW'($urandom % 8);
      tick("R5 R6 R7 R8 traffic");
    end
    idle_ev();
    for (int c = 0; c < 20; c++) tick("R1 settle");

    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule